// File: doc/BRIEF.md
# Single-Input Interrupt Controller

This block sits beside the fetch and decode logic of a small microcontroller core. It decides when the core's only external interrupt request may break into normal execution. It keeps the interrupt-enable flag, which the core's decoder changes through three strobes: an enable command, a disable command, and the interrupt-return command, whose operand bit says whether interrupts come back on or stay off. A request is captured only after it has been seen high on a fixed number of consecutive clock edges (two by default) while interrupts are enabled. The capture is held until the core reports an instruction boundary.

When it accepts a request, the block clears the enable flag. For one cycle it raises a redirect strobe, which carries the vector address that the next fetch must use, together with a push strobe for the return stack. In that same cycle it pulses the acknowledge output so the requester can drop its line. It also stores the core's condition flags and register-bank select in a shadow register. On the interrupt return it hands them back with a one-cycle restore strobe. The return stack itself is outside this block, and so is any merging of several request sources.

Top module: `irq_sequencer`

## Requirements
- R1: While `rst` is high and on the first clock edge after it, `int_en`, `take_vec`, `push_ret`, `irq_ack` and `ctx_restore_vld` are 0 and `vec_addr` is 0. Reset also discards any captured request, so a later enable with the line low and a boundary gives no redirect.
- R2: At the next clock edge, `cmd_enable` sets `int_en` to 1 and `cmd_disable` clears it to 0. When both strobes are high, disable wins.
- R3: A request is captured only when `irq_req` is 1 on QUAL_LEN (default 2) consecutive edges and `int_en` is 1 at the last of them. A request that is high on only one edge is never taken.
- R4: A captured request is taken only on an edge where `instr_boundary` is 1 and `int_en` is 1. Until then it stays pending, even if `irq_req` has fallen.
- R5: When a request is taken, `take_vec`, `push_ret` and `irq_ack` are 1 for exactly the one cycle after that edge. During that cycle `vec_addr` equals VEC_ADDR (default 0x3FF). In every other cycle it is 0.
- R6: Taking a request clears `int_en` at the same edge. This also applies when `cmd_enable` is high in the same cycle.
- R7: A `cmd_disable` in the boundary cycle blocks the take and discards the pending request. A later enable followed by a boundary, with the line low, gives no redirect.
- R8: `ret_int` sets `int_en` to the value of `ret_arg` (1 = enabled, 0 = disabled) at the next edge.
- R9: Taking a request stores `flags_in` and `bank_in`. The cycle after `ret_int`, `ctx_restore_vld` is 1 and `ctx_flags_out`/`ctx_bank_out` hold the stored values, even if the inputs have since changed. `ctx_restore_vld` is 0 in other cycles.
- R10: If `irq_req` is still high when a return re-enables interrupts, the request is captured again on the next edge and taken on the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous core reset, active high |
| irq_req | input | 1 | External interrupt request line |
| cmd_enable | input | 1 | Decoder strobe: turn interrupts on |
| cmd_disable | input | 1 | Decoder strobe: turn interrupts off |
| ret_int | input | 1 | Decoder strobe: interrupt return |
| ret_arg | input | 1 | Operand of interrupt return, 1 = re-enable |
| instr_boundary | input | 1 | High in the last cycle of an instruction |
| flags_in | input | FLAG_W | Current condition flags of the core |
| bank_in | input | BANK_W | Current register-bank select |
| int_en | output | 1 | Interrupt-enable flag |
| take_vec | output | 1 | Redirect next fetch to `vec_addr` |
| vec_addr | output | ADDR_W | Vector address while `take_vec`, else 0 |
| push_ret | output | 1 | Push return address onto the call stack |
| irq_ack | output | 1 | Acknowledge pulse to the requester |
| ctx_restore_vld | output | 1 | Restore strobe for flags and bank |
| ctx_flags_out | output | FLAG_W | Saved flags to restore |
| ctx_bank_out | output | BANK_W | Saved bank select to restore |

## Verification
Every output comes from a register, so each result shows up exactly one edge after the input cycle that causes it. The enable flag, the redirect and acknowledge pulses, and the restore strobe all follow this rule. A request needs QUAL_LEN edges to be captured and one more boundary edge to be taken. The bench changes inputs on the falling edge and reads outputs 1 ns after the rising edge, so each check compares the state that results from the vector applied just before that edge. Every check is placed at the edge on which the requirement says the value becomes due.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Why the enable flag changes in a given cycle (priority order)
    typedef enum logic [2:0] {
        IE_HOLD    = 3'd0,
        IE_CMD_OFF = 3'd1,
        IE_TAKEN   = 3'd2,
        IE_RETURN  = 3'd3,
        IE_CMD_ON  = 3'd4
    } ie_cause_e;

    typedef struct packed {
        logic ie;
    } ie_state_t;

    typedef struct packed {
        logic take;
        logic push;
        logic ack;
    } entry_state_t;

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_enable,
    input  logic cmd_disable,
    input  logic ret_int,
    input  logic ret_arg,
    input  logic accept,
    output logic ie_q_o,
    output logic ie_d_o
);

    ie_state_t state_d, state_q;
    ie_cause_e cause;

    always_comb begin
        state_d = state_q;
        cause   = IE_HOLD;
        if (cmd_disable) begin
            cause = IE_CMD_OFF;
        end else if (accept) begin
            cause = IE_TAKEN;
        end else if (ret_int) begin
            cause = IE_RETURN;
        end else if (cmd_enable) begin
            cause = IE_CMD_ON;
        end
        unique case (cause)
            IE_CMD_OFF: state_d.ie = 1'b0;
            IE_TAKEN:   state_d.ie = 1'b0;
            IE_RETURN:  state_d.ie = ret_arg;
            IE_CMD_ON:  state_d.ie = 1'b1;
            default:    state_d.ie = state_q.ie;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ie_q_o = state_q.ie;
    assign ie_d_o = state_d.ie;

    AST_ENABLE_CMD_SETS: assert property (@(posedge clk) disable iff (rst)
        (cmd_enable && !cmd_disable && !accept && !ret_int) |=> ie_q_o); // R2
    AST_DISABLE_CMD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cmd_disable |=> !ie_q_o); // R2
    AST_RETURN_ARG: assert property (@(posedge clk) disable iff (rst)
        (ret_int && !cmd_disable && !accept) |=> (ie_q_o == $past(ret_arg))); // R8

endmodule

// File: rtl/irq_req_qual.sv
module irq_req_qual #(
    parameter int QUAL_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_req,
    input  logic ie_now,
    input  logic ie_next,
    input  logic accept,
    output logic pending
);

    localparam int CNT_W   = $clog2(QUAL_LEN + 1);
    localparam int CNT_MAX = QUAL_LEN - 1;

    typedef struct packed {
        logic [CNT_W-1:0] run;
        logic             pend;
    } qual_state_t;

    qual_state_t state_d, state_q;
    logic        qualified;

    generate
        if (QUAL_LEN < 2) begin : g_direct
            assign qualified = irq_req && ie_now;
        end else begin : g_count
            assign qualified = irq_req && ie_now &&
                               (state_q.run >= CNT_W'(CNT_MAX));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        // consecutive-high run length, saturating
        if (!irq_req) begin
            state_d.run = '0;
        end else if (state_q.run < CNT_W'(CNT_MAX)) begin
            state_d.run = state_q.run + CNT_W'(1);
        end
        // capture / release of the pending request
        if (accept || !ie_next) begin
            state_d.pend = 1'b0;
        end else if (qualified) begin
            state_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pending = state_q.pend;

    AST_CAPTURE_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> ($past(irq_req) && $past(ie_now))); // R3

endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow #(
    parameter int FLAG_W = 2,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              ret_int,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic              restore_vld,
    output logic [FLAG_W-1:0] flags_out,
    output logic [BANK_W-1:0] bank_out
);

    typedef struct packed {
        logic [FLAG_W-1:0] sflags;
        logic [BANK_W-1:0] sbank;
        logic              vld;
        logic [FLAG_W-1:0] oflags;
        logic [BANK_W-1:0] obank;
    } ctx_state_t;

    ctx_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.vld = 1'b0;
        if (ret_int) begin
            state_d.vld    = 1'b1;
            state_d.oflags = state_q.sflags;
            state_d.obank  = state_q.sbank;
        end
        if (accept) begin
            state_d.sflags = flags_in;
            state_d.sbank  = bank_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign restore_vld = state_q.vld;
    assign flags_out   = state_q.oflags;
    assign bank_out    = state_q.obank;

    AST_RESTORE_FROM_RETURN: assert property (@(posedge clk) disable iff (rst)
        restore_vld |-> $past(ret_int)); // R9

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] VEC_ADDR = 12'h3FF,
    parameter int          QUAL_LEN = 2,
    parameter int          FLAG_W   = 2,
    parameter int          BANK_W   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              ret_int,
    input  logic              ret_arg,
    input  logic              instr_boundary,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic              int_en,
    output logic              take_vec,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              push_ret,
    output logic              irq_ack,
    output logic              ctx_restore_vld,
    output logic [FLAG_W-1:0] ctx_flags_out,
    output logic [BANK_W-1:0] ctx_bank_out
);
    import irq_pkg::*;

    localparam logic [ADDR_W-1:0] VEC = ADDR_W'(VEC_ADDR);

    logic         ie_q, ie_d;
    logic         pend;
    logic         accept;
    entry_state_t entry_d, entry_q;

    // take only on a boundary, while enabled, unless disabled this cycle
    assign accept = pend && instr_boundary && ie_q && !cmd_disable;

    irq_enable_reg u_ie (
        .clk         (clk),
        .rst         (rst),
        .cmd_enable  (cmd_enable),
        .cmd_disable (cmd_disable),
        .ret_int     (ret_int),
        .ret_arg     (ret_arg),
        .accept      (accept),
        .ie_q_o      (ie_q),
        .ie_d_o      (ie_d)
    );

    irq_req_qual #(.QUAL_LEN(QUAL_LEN)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .irq_req (irq_req),
        .ie_now  (ie_q),
        .ie_next (ie_d),
        .accept  (accept),
        .pending (pend)
    );

    irq_ctx_shadow #(.FLAG_W(FLAG_W), .BANK_W(BANK_W)) u_ctx (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .ret_int     (ret_int),
        .flags_in    (flags_in),
        .bank_in     (bank_in),
        .restore_vld (ctx_restore_vld),
        .flags_out   (ctx_flags_out),
        .bank_out    (ctx_bank_out)
    );

    always_comb begin
        entry_d      = '0;
        entry_d.take = accept;
        entry_d.push = accept;
        entry_d.ack  = accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= '0;
        end else begin
            entry_q <= entry_d;
        end
    end

    assign int_en   = ie_q;
    assign take_vec = entry_q.take;
    assign push_ret = entry_q.push;
    assign irq_ack  = entry_q.ack;
    assign vec_addr = entry_q.take ? VEC : '0;

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        take_vec |-> $past(instr_boundary)); // R4
    AST_TAKE_WHILE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        take_vec |-> $past(int_en)); // R4
    AST_TAKE_CLEARS_IE: assert property (@(posedge clk) disable iff (rst)
        take_vec |-> !int_en); // R6
    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        take_vec |=> !take_vec); // R5
    AST_NO_TAKE_AFTER_DISABLE: assert property (@(posedge clk) disable iff (rst)
        $past(cmd_disable) |-> !take_vec); // R7

endmodule

// File: tb/sim_irq_sequencer.sv
module sim_irq_sequencer;

    localparam int FW = 2;
    localparam int BW = 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          irq_req, cmd_enable, cmd_disable, ret_int, ret_arg, instr_boundary;
    logic [FW-1:0] flags_in;
    logic [BW-1:0] bank_in;
    logic          int_en, take_vec, push_ret, irq_ack, ctx_restore_vld;
    logic [11:0]   vec_addr;
    logic [FW-1:0] ctx_flags_out;
    logic [BW-1:0] ctx_bank_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_sequencer u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .cmd_enable(cmd_enable),
        .cmd_disable(cmd_disable), .ret_int(ret_int), .ret_arg(ret_arg),
        .instr_boundary(instr_boundary), .flags_in(flags_in), .bank_in(bank_in),
        .int_en(int_en), .take_vec(take_vec), .vec_addr(vec_addr),
        .push_ret(push_ret), .irq_ack(irq_ack), .ctx_restore_vld(ctx_restore_vld),
        .ctx_flags_out(ctx_flags_out), .ctx_bank_out(ctx_bank_out)
    );

    // {irq, en, dis, reti, rarg, bnd, exp_ie, exp_take}
    localparam logic [7:0] VECS [22] = '{
        8'b100001_00, // 0  R3 line high, interrupts off
        8'b100001_00, // 1  R3 two edges but off: no capture
        8'b010000_10, // 2  R2 enable
        8'b100001_10, // 3  R3 first high edge
        8'b000001_10, // 4  R3 single-edge pulse ignored at boundary
        8'b100000_10, // 5  run 1
        8'b100000_10, // 6  captured
        8'b000000_10, // 7  R4 no boundary: held
        8'b000001_01, // 8  R4 R5 R6 taken
        8'b000001_00, // 9  R5 single pulse
        8'b000111_10, // 10 R8 return with enable
        8'b100000_10, // 11 run 1
        8'b100000_10, // 12 captured
        8'b110001_01, // 13 R6 take beats enable
        8'b100001_00, // 14 off: no capture
        8'b000101_00, // 15 R8 return with disable
        8'b010000_10, // 16 R2 enable
        8'b100000_10, // 17 run 1
        8'b100000_10, // 18 captured
        8'b001001_00, // 19 R7 disable at boundary blocks take
        8'b010000_10, // 20 enable again
        8'b000001_10  // 21 R7 pending was discarded
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic i, input logic en, input logic dis,
                        input logic ri, input logic ra, input logic b);
        @(negedge clk);
        irq_req = i; cmd_enable = en; cmd_disable = dis;
        ret_int = ri; ret_arg = ra; instr_boundary = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        irq_req = 0; cmd_enable = 0; cmd_disable = 0; ret_int = 0; ret_arg = 0;
        instr_boundary = 0; flags_in = '0; bank_in = '0;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_take(input string req, input logic exp);
        check({req, " take_vec"}, take_vec, exp);
        check({req, " irq_ack"}, irq_ack, exp);
        check({req, " push_ret"}, push_ret, exp);
        check({req, " vec_addr"}, vec_addr, exp ? 32'h3FF : 32'h0);
    endtask

    initial begin
        rst = 1'b1;
        do_reset();
        // R1 reset state
        step(0, 0, 0, 0, 0, 0);
        check("R1 int_en", int_en, 0);
        check_take("R1", 1'b0);
        check("R1 restore", ctx_restore_vld, 0);

        for (int k = 0; k < 22; k++) begin
            step(VECS[k][7], VECS[k][6], VECS[k][5], VECS[k][4], VECS[k][3], VECS[k][2]);
            check($sformatf("R2/R8 ie row %0d", k), int_en, VECS[k][1]);
            check_take($sformatf("R3-R7 row %0d", k), VECS[k][0]);
        end

        // R9 context save and restore
        do_reset();
        step(0, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        flags_in = 2'b10; bank_in = 1'b1;
        step(0, 0, 0, 0, 0, 1);
        check_take("R9 entry", 1'b1);
        flags_in = 2'b01; bank_in = 1'b0;
        step(0, 0, 0, 0, 0, 1);
        check("R9 no restore yet", ctx_restore_vld, 0);
        step(0, 0, 0, 1, 1, 1);
        check("R9 restore_vld", ctx_restore_vld, 1);
        check("R9 flags", ctx_flags_out, 2'b10);
        check("R9 bank", ctx_bank_out, 1'b1);
        check("R8 re-enabled", int_en, 1);
        step(0, 0, 0, 0, 0, 0);
        check("R9 restore single", ctx_restore_vld, 0);

        // R10 line held across a return
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 1);
        check_take("R10 first take", 1'b1);
        step(1, 0, 0, 1, 1, 1);
        check("R10 ie after return", int_en, 1);
        check_take("R10 none at return", 1'b0);
        step(1, 0, 0, 0, 0, 0);
        check_take("R10 capture edge", 1'b0);
        step(1, 0, 0, 0, 0, 1);
        check_take("R10 retaken", 1'b1);

        // R1 reset discards a pending request
        do_reset();
        step(0, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        do_reset();
        step(0, 0, 0, 0, 0, 0);
        check("R1 ie after reset", int_en, 0);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        check_take("R1 pending dropped", 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule